// File: doc/BRIEF.md
# Indirect Segment Descriptor File

This block stores a small set of segment descriptors. Each holds a base, a mask and a status byte whose bit 0 is the segment enable. Software never addresses a descriptor directly. It writes an index into a pointer register and then works through a five-byte staging accumulator. A transfer copies the pointed-to descriptor into the accumulator, so the individual fields can be read back byte by byte. A load writes the whole accumulator into the pointed-to descriptor. A status write is a short path that rewrites only the status byte of the pointed-to descriptor. It may clear the enable bit but can never set it.

Requests arrive from an operation controller as a level `op_req` carrying a 6-bit register address, a direction and a data byte. A three-state machine serves them: S_IDLE, S_EXEC and S_ACK. In S_IDLE, a raised `op_req` is captured and the machine moves to S_EXEC. S_EXEC carries out the decoded action, latches the read byte and moves to S_ACK. S_ACK holds `op_ack` until `op_req` falls, then returns to S_IDLE.

The address map is as follows:
- 0x20: pointer register.
- 0x28 to 0x2C: accumulator bytes, in the order base high, base low, mask high, mask low, status.
- 0x31, read: transfer.
- 0x31, write: status write.
- 0x3F, write: load.
- Every other case: null operation.

Top module: `desc_file`

## Requirements
- R1: After reset `op_ack` is low, the pointer reads 0, and every descriptor's status (bit 0 being the enable) is 0x00.
- R2: A write to 0x20 stores only the low 5 bits of the data as the pointer. A read of 0x20 returns the pointer zero-extended.
- R3: The five accumulator bytes at 0x28 (base high), 0x29 (base low), 0x2A (mask high), 0x2B (mask low) and 0x2C (status) can each be written and read directly.
- R4: A read of 0x31 copies the pointed-to descriptor into all five accumulator bytes and returns that descriptor's status byte in the same response.
- R5: A write to 0x3F copies all five accumulator bytes into the pointed-to descriptor, including an enable bit of 1.
- R6: A write to 0x31 sets status bits 7..1 of the pointed-to descriptor from the data. Bit 0 becomes the old enable ANDed with data bit 0. The accumulator is not changed.
- R7: A read of any unmapped address, and a read of 0x3F, returns 0xFF. A write to any unmapped address changes no pointer, accumulator or descriptor state.
- R8: A request raised before a rising edge gets `op_ack` two rising edges later. `op_ack` and `op_rdata` (0x00 for writes) stay steady while `op_req` stays high. `op_ack` drops at the first edge after `op_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_req | input | 1 | Operation request level |
| op_we | input | 1 | 1 = write, 0 = read |
| op_addr | input | 6 | Register address |
| op_wdata | input | 8 | Write data byte |
| op_ack | output | 1 | Operation complete, held while op_req is high |
| op_rdata | output | 8 | Read data, valid while op_ack is high |

## Verification
The bench targets several faults, each with a visible symptom:
- Enable bit: it is set through the status-write path, and a design that ORs or passes the data bit would report an enabled descriptor afterwards.
- Out-of-range pointer: a value such as 0x25 is written, and a design that does not mask it reads back the wrong pointer or reaches the wrong descriptor.
- Accumulator after a status write: it is read back, and a design that mirrors the status write into the accumulator shows a changed status byte.
- Unmapped accesses: writes are followed by read-back of all reachable state, and reads of the load address expose a design that transfers or returns stale data instead of 0xFF.

// File: rtl/desc_file_pkg.sv
package desc_file_pkg;

    localparam int SEG_W   = 16;
    localparam int REG_AW  = 6;
    localparam int EN_BIT  = 0;
    localparam int ACC_NB  = 5;

    localparam logic [REG_AW-1:0] A_PTR  = 6'h20;
    localparam logic [REG_AW-1:0] A_ACC0 = 6'h28;
    localparam logic [REG_AW-1:0] A_STAT = 6'h31;
    localparam logic [REG_AW-1:0] A_LOAD = 6'h3F;

    typedef struct packed {
        logic [SEG_W-1:0] base;
        logic [SEG_W-1:0] mask;
        logic [7:0]       status;
    } desc_t;

    typedef enum logic [2:0] {
        OP_NULL,
        OP_PTR,
        OP_ACC,
        OP_STAT,
        OP_LOAD
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_ACK
    } state_e;

    function automatic op_kind_e decode_op(input logic [REG_AW-1:0] a, input logic we);
        op_kind_e k;
        if (a == A_PTR)
            k = OP_PTR;
        else if (a >= A_ACC0 && a < A_ACC0 + REG_AW'(ACC_NB))
            k = OP_ACC;
        else if (a == A_STAT)
            k = OP_STAT;
        else if (a == A_LOAD && we)
            k = OP_LOAD;
        else
            k = OP_NULL;
        return k;
    endfunction

endpackage

// File: rtl/desc_file_ctrl.sv
module desc_file_ctrl
    import desc_file_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_req,
    input  logic              op_we,
    input  logic [REG_AW-1:0] op_addr,
    input  logic [7:0]        op_wdata,
    input  logic [7:0]        rd_byte,
    output op_kind_e          cmd_kind,
    output logic [2:0]        cmd_sel,
    output logic [7:0]        cmd_wdata,
    output logic              ptr_we,
    output logic              acc_we,
    output logic              xfer,
    output logic              load,
    output logic              st_we,
    output logic              op_ack,
    output logic [7:0]        op_rdata
);

    state_e            state_q, state_d;
    op_kind_e          kind_q;
    logic              we_q;
    logic [REG_AW-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;
    logic [REG_AW-1:0] acc_off;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= OP_NULL;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && op_req) begin
                kind_q  <= decode_op(op_addr, op_we);
                we_q    <= op_we;
                addr_q  <= op_addr;
                wdata_q <= op_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (op_req) state_d = S_EXEC;
            S_EXEC: state_d = S_ACK;
            S_ACK:  if (!op_req) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ptr_we = 1'b0;
        acc_we = 1'b0;
        xfer   = 1'b0;
        load   = 1'b0;
        st_we  = 1'b0;
        if (state_q == S_EXEC) begin
            unique case (kind_q)
                OP_PTR:  ptr_we = we_q;
                OP_ACC:  acc_we = we_q;
                OP_STAT: begin
                    xfer  = !we_q;
                    st_we = we_q;
                end
                OP_LOAD: load = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == S_EXEC)
            rdata_q <= we_q ? 8'h00 : rd_byte;
    end

    assign acc_off   = addr_q - A_ACC0;
    assign cmd_sel   = acc_off[2:0];
    assign cmd_kind  = kind_q;
    assign cmd_wdata = wdata_q;
    assign op_ack    = (state_q == S_ACK);
    assign op_rdata  = rdata_q;

    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ack && op_req) |=> op_ack);
    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ack && !op_req) |=> !op_ack);
    assert_rdata_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ack && $past(op_ack)) |-> $stable(op_rdata));
    assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_we, acc_we, xfer, load, st_we}));

endmodule

// File: rtl/desc_acc.sv
module desc_acc
    import desc_file_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic             acc_we,
    input  logic             xfer,
    input  logic [2:0]       sel,
    input  logic [7:0]       wdata,
    input  desc_t            desc_in,
    output logic [PTR_W-1:0] ptr,
    output desc_t            acc
);

    logic [PTR_W-1:0] ptr_q;
    desc_t            acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_we)
            ptr_q <= wdata[PTR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (xfer) begin
            acc_q <= desc_in;
        end else if (acc_we) begin
            unique case (sel)
                3'd0:    acc_q.base[15:8] <= wdata;
                3'd1:    acc_q.base[7:0]  <= wdata;
                3'd2:    acc_q.mask[15:8] <= wdata;
                3'd3:    acc_q.mask[7:0]  <= wdata;
                default: acc_q.status     <= wdata;
            endcase
        end
    end

    assign ptr = ptr_q;
    assign acc = acc_q;

    assert_ptr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> ptr == $past(wdata[PTR_W-1:0]));
    assert_xfer_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> acc == $past(desc_in));
    assert_acc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !acc_we) |=> $stable(acc));

endmodule

// File: rtl/desc_store.sv
module desc_store
    import desc_file_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int PTR_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] idx,
    input  logic             load,
    input  logic             st_we,
    input  logic [7:0]       wdata,
    input  desc_t            acc,
    output desc_t            rd_desc
);

    desc_t entries [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
        logic hit;
        logic [7:0] st_next;
        assign hit = (int'(idx) == g);
        always_comb begin
            st_next         = wdata;
            st_next[EN_BIT] = wdata[EN_BIT] & entries[g].status[EN_BIT];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entries[g] <= '0;
            else if (hit && load)
                entries[g] <= acc;
            else if (hit && st_we)
                entries[g].status <= st_next;
        end
    end

    assign rd_desc = entries[idx];

    assert_no_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !rd_desc.status[EN_BIT]) |=> !entries[$past(idx)].status[EN_BIT]);
    assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> entries[$past(idx)] == $past(acc));

endmodule

// File: rtl/desc_file.sv
module desc_file
    import desc_file_pkg::*;
#(
    parameter int NUM_DESC = 32,
    parameter int PTR_W    = $clog2(NUM_DESC)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_req,
    input  logic       op_we,
    input  logic [5:0] op_addr,
    input  logic [7:0] op_wdata,
    output logic       op_ack,
    output logic [7:0] op_rdata
);

    op_kind_e         cmd_kind;
    logic [2:0]       cmd_sel;
    logic [7:0]       cmd_wdata;
    logic             ptr_we, acc_we, xfer, load, st_we;
    logic [7:0]       rd_byte;
    logic [PTR_W-1:0] ptr;
    desc_t            acc;
    desc_t            rd_desc;

    desc_file_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .rd_byte(rd_byte),
        .cmd_kind(cmd_kind), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
        .ptr_we(ptr_we), .acc_we(acc_we), .xfer(xfer), .load(load), .st_we(st_we),
        .op_ack(op_ack), .op_rdata(op_rdata)
    );

    desc_acc #(.PTR_W(PTR_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .ptr_we(ptr_we), .acc_we(acc_we), .xfer(xfer),
        .sel(cmd_sel), .wdata(cmd_wdata), .desc_in(rd_desc),
        .ptr(ptr), .acc(acc)
    );

    desc_store #(.NUM_DESC(NUM_DESC), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .idx(ptr), .load(load), .st_we(st_we), .wdata(cmd_wdata),
        .acc(acc), .rd_desc(rd_desc)
    );

    // read byte selection for the captured request
    always_comb begin
        rd_byte = 8'hFF;
        unique case (cmd_kind)
            OP_PTR:  rd_byte = 8'(ptr);
            OP_ACC: begin
                unique case (cmd_sel)
                    3'd0:    rd_byte = acc.base[15:8];
                    3'd1:    rd_byte = acc.base[7:0];
                    3'd2:    rd_byte = acc.mask[15:8];
                    3'd3:    rd_byte = acc.mask[7:0];
                    default: rd_byte = acc.status;
                endcase
            end
            OP_STAT: rd_byte = rd_desc.status;
            default: rd_byte = 8'hFF;
        endcase
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_req && !op_ack) |=> !op_ack);

endmodule

// File: tb/desc_file_tb.sv
module desc_file_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_req = 1'b0;
    logic       op_we = 1'b0;
    logic [5:0] op_addr = '0;
    logic [7:0] op_wdata = '0;
    logic       op_ack;
    logic [7:0] op_rdata;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model
    int m_ptr;
    int m_acc [5];
    int m_desc [32][5];

    always #2 clk = ~clk;

    desc_file u_dut (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_we(op_we),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_ack(op_ack), .op_rdata(op_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_op(input bit we, input int a, input int d);
        int rd;
        rd = we ? 0 : 255;
        if (a == 'h20) begin
            if (!we) rd = m_ptr; else m_ptr = d % 32;
        end else if (a >= 'h28 && a <= 'h2C) begin
            if (!we) rd = m_acc[a - 'h28]; else m_acc[a - 'h28] = d;
        end else if (a == 'h31) begin
            if (!we) begin
                for (int i = 0; i < 5; i++) m_acc[i] = m_desc[m_ptr][i];
                rd = m_desc[m_ptr][4];
            end else begin
                m_desc[m_ptr][4] = (d & 'hFE) | (d & m_desc[m_ptr][4] & 1);
            end
        end else if (a == 'h3F && we) begin
            for (int i = 0; i < 5; i++) m_desc[m_ptr][i] = m_acc[i];
        end
        return rd;
    endfunction

    task automatic xact(input bit we, input int a, input int d, input string tag);
        int exp;
        exp = model_op(we, a, d);
        @(negedge clk);
        op_req = 1'b1; op_we = we; op_addr = 6'(a); op_wdata = 8'(d);
        @(negedge clk);
        check({tag, " R8 ack low after capture"}, int'(op_ack), 0);
        @(negedge clk);
        check({tag, " R8 ack high"}, int'(op_ack), 1);
        check({tag, " data"}, int'(op_rdata), exp);
        @(negedge clk);
        check({tag, " R8 ack held"}, int'(op_ack), 1);
        check({tag, " R8 data held"}, int'(op_rdata), exp);
        op_req = 1'b0;
        @(negedge clk);
        check({tag, " R8 ack released"}, int'(op_ack), 0);
    endtask

    task automatic read_all_acc(input string tag);
        for (int i = 0; i < 5; i++) xact(1'b0, 'h28 + i, 0, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        m_ptr = 0;
        for (int i = 0; i < 5; i++) m_acc[i] = 0;
        for (int j = 0; j < 32; j++)
            for (int i = 0; i < 5; i++) m_desc[j][i] = 0;

        repeat (3) @(negedge clk);
        check("R1 ack in reset", int'(op_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", int'(op_ack), 0);

        xact(1'b0, 'h20, 0, "R1 pointer");
        xact(1'b1, 'h20, 31, "R1 ptr31");
        xact(1'b0, 'h31, 0, "R1 status 31");
        xact(1'b1, 'h20, 0, "R1 ptr0");
        xact(1'b0, 'h31, 0, "R1 status 0");

        xact(1'b1, 'h20, 'h25, "R2 ptr write");
        xact(1'b0, 'h20, 0, "R2 ptr masked");
        xact(1'b1, 'h20, 'hE3, "R2 ptr write");
        xact(1'b0, 'h20, 0, "R2 ptr masked");

        xact(1'b1, 'h28, 'h12, "R3 base hi");
        xact(1'b1, 'h29, 'h34, "R3 base lo");
        xact(1'b1, 'h2A, 'hF0, "R3 mask hi");
        xact(1'b1, 'h2B, 'h0F, "R3 mask lo");
        xact(1'b1, 'h2C, 'h81, "R3 status");
        read_all_acc("R3 readback");

        xact(1'b1, 'h20, 5, "R5 ptr");
        xact(1'b1, 'h3F, 0, "R5 load");
        for (int i = 0; i < 5; i++) xact(1'b1, 'h28 + i, 0, "R3 clear");
        xact(1'b0, 'h31, 0, "R4 transfer enabled");
        read_all_acc("R4 fields");

        xact(1'b1, 'h2C, 'h55, "R3 acc status");
        xact(1'b1, 'h31, 'h7E, "R6 clear enable");
        xact(1'b0, 'h2C, 0, "R6 acc untouched");
        xact(1'b1, 'h31, 'hFF, "R6 try set enable");
        xact(1'b0, 'h31, 0, "R6 enable stays clear");

        xact(1'b0, 'h00, 0, "R7 unmapped read");
        xact(1'b0, 'h3F, 0, "R7 load addr read");
        xact(1'b0, 'h2D, 0, "R7 past acc read");
        xact(1'b1, 'h10, 'hAA, "R7 unmapped write");
        xact(1'b1, 'h21, 'h03, "R7 unmapped write");
        xact(1'b0, 'h20, 0, "R7 ptr kept");
        read_all_acc("R7 acc kept");
        xact(1'b0, 'h31, 0, "R7 desc kept");

        for (int j = 0; j < 32; j++) begin
            xact(1'b1, 'h20, j, "R5 sweep ptr");
            xact(1'b1, 'h28, j * 3, "R3 sweep");
            xact(1'b1, 'h2B, 255 - j, "R3 sweep");
            xact(1'b1, 'h2C, (j * 7) & 255, "R3 sweep");
            xact(1'b1, 'h3F, 0, "R5 sweep load");
        end
        for (int j = 31; j >= 0; j--) begin
            xact(1'b1, 'h20, j, "R4 sweep ptr");
            xact(1'b0, 'h31, 0, "R4 sweep transfer");
            xact(1'b0, 'h28, 0, "R4 sweep base hi");
            xact(1'b0, 'h2B, 0, "R4 sweep mask lo");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule